// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of byte-wide configuration registers for the rest of the chip. A host loads the bank with a block write: the device address, two leading bytes that are acknowledged and then thrown away, and a run of data bytes that fill the registers in ascending order from register 0. The host may end the write with a stop after any whole byte. Registers it did not reach keep their old values. A block read returns a byte count and then the whole bank, register 0 first.

The serial clock and data lines are oversampled by the system clock, which must run at least ten times faster than the serial clock. Start and stop are detected from data edges while the serial clock is high. The block never drives the data line high. It pulls the line low through an output enable, and the pad logic builds the open-drain wire from that enable. Register 0 is also decoded into a frequency source select, a 5-bit frequency code, a spread enable and a global output-off flag.

The controller is one state machine:
- **ST_IDLE** waits for a start.
- **ST_RX** shifts in eight bits on rising serial clock edges. On the falling edge after the eighth bit it moves to ST_ACK, or to ST_IDLE if the address does not match.
- **ST_ACK** holds the data line low for one bit. On the next falling edge it moves to ST_RX when writing, or loads a byte and moves to ST_TX when reading.
- **ST_TX** drives eight bits, MSB first, changing them on falling edges. It moves to ST_RACK after the eighth bit.
- **ST_RACK** samples the host's acknowledge on the rising edge. On the falling edge it moves to ST_TX if the host acknowledged, or to ST_IDLE if it did not.

From any state, a stop goes to ST_IDLE and a start goes to ST_RX in address phase.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The block acknowledges the 8-bit address byte 0xD2 (write) and 0xD3 (read). For any other address it never pulls the data line low, and the registers do not change.
- R2: In a write, the first two bytes after the address are acknowledged and discarded. A write that carries only those two bytes leaves every register unchanged.
- R3: In a write, the third and later bytes after the address are acknowledged and stored into register 0, 1, 2 and so on, in arrival order.
- R4: A stop after any whole data byte keeps the bytes stored so far, and the remaining registers keep their earlier values.
- R5: Data bytes beyond register 5 are acknowledged and have no effect on any register.
- R6: A read sends the count byte 6 first, then registers 0 through 5, each MSB first. A read never changes any register.
- R7: After reset, register 0 is 0x00 and registers 1 through 5 are 0xFF.
- R8: Register 0 is decoded as follows:
  - bit 3 drives `use_reg_freq`;
  - `freq_code` is {bit 2, bits 7:4}, with bit 2 as the MSB;
  - bit 1 drives `spread_en`;
  - bit 0 drives `outputs_off`.
- R9: A start received in the middle of a transfer (a repeated start) resets the byte index and begins a new address phase. A following write therefore lands at register 0 again.
- R10: The block changes the data-line enable only while the serial clock is low, so the line stays stable for the whole high phase of every bit the block drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_bytes | output | 48 | Register bank, register i at bits [8i+7:8i] |
| use_reg_freq | output | 1 | 1 selects the frequency code from register 0 |
| freq_code | output | 5 | Frequency code {reg0[2], reg0[7:4]} |
| spread_en | output | 1 | Spread enable, reg0[1] |
| outputs_off | output | 1 | Output-off request, reg0[0] |

## Verification
The bench uses the default parameters: six registers, a two-stage line synchronizer and device address 0x69. The serial clock period is 40 system clocks, so every bit phase lasts far longer than the synchronizer latency.

With six registers, one transfer can cover all of these cases:
- a full bank;
- a truncated write;
- writes past the last register.

Because the byte counter saturates well above that range, writes past the last register never wrap around onto register 0. The short register count also keeps each read-back short enough that several random write and read rounds fit in one run.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } link_state_t;

    // power-on value of register i: register 0 clear, enable bytes all set
    function automatic logic [7:0] reg_default(input int idx);
        return (idx == 0) ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/cfg_i2c_sync.sv
module cfg_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS = 6,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic [CNT_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [7:0]       COUNT_B = 8'(NUM_REGS);

    link_state_t      state, state_n;
    logic [3:0]       bit_cnt, bit_n;
    logic [7:0]       sh, sh_n;
    logic [CNT_W-1:0] byte_no, byte_n;
    logic             addr_ph, addr_n;
    logic             is_rd, rd_n;
    logic             ack_ok, ack_n;
    logic [7:0]       tx_load;
    logic [CNT_W-1:0] byte_inc;

    assign rd_idx   = byte_no - 1'b1;
    assign tx_load  = (byte_no == '0) ? COUNT_B : rd_data;
    assign byte_inc = (byte_no == CNT_MAX) ? byte_no : byte_no + 1'b1;
    assign wr_idx   = byte_no - 2'd2;
    assign wr_data  = sh;

    always_comb begin
        state_n = state;
        bit_n   = bit_cnt;
        sh_n    = sh;
        byte_n  = byte_no;
        addr_n  = addr_ph;
        rd_n    = is_rd;
        ack_n   = ack_ok;
        wr_en   = 1'b0;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_RX;
            bit_n   = '0;
            byte_n  = '0;
            addr_n  = 1'b1;
            rd_n    = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        sh_n  = {sh[6:0], sda_s};
                        bit_n = bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        bit_n = '0;
                        if (addr_ph) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                state_n = ST_ACK;
                                rd_n    = sh[0];
                                addr_n  = 1'b0;
                                byte_n  = '0;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end else begin
                            state_n = ST_ACK;
                            wr_en   = (byte_no >= 2);
                            byte_n  = byte_inc;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_n = '0;
                        if (is_rd) begin
                            state_n = ST_TX;
                            sh_n    = tx_load;
                            byte_n  = byte_inc;
                        end else begin
                            state_n = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_n = bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == 4'd8) state_n = ST_RACK;
                        else                 sh_n = {sh[6:0], 1'b1};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ack_n = ~sda_s;
                    end else if (scl_fall) begin
                        if (ack_ok) begin
                            state_n = ST_TX;
                            sh_n    = tx_load;
                            byte_n  = byte_inc;
                            bit_n   = '0;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            byte_no <= '0;
            addr_ph <= 1'b0;
            is_rd   <= 1'b0;
            ack_ok  <= 1'b0;
        end else begin
            state   <= state_n;
            bit_cnt <= bit_n;
            sh      <= sh_n;
            byte_no <= byte_n;
            addr_ph <= addr_n;
            is_rd   <= rd_n;
            ack_ok  <= ack_n;
        end
    end

    always_comb begin
        sda_oe = (state == ST_ACK) || (state == ST_TX && !sh[7]);
    end

    assert_start_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_RX && bit_cnt == 4'd0 && addr_ph));

    assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int CNT_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CNT_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [CNT_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    localparam logic [CNT_W-1:0] NREG_C = CNT_W'(NUM_REGS);

    logic [7:0] q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   q[i] <= reg_default(i);
            else if (wr_en && wr_idx == CNT_W'(i))        q[i] <= wr_data;
        end
        assign cfg_flat[i*8 +: 8] = q[i];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == CNT_W'(i)) rd_data = q[i];
        end
    end

    assert_oob_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= NREG_C) |=> $stable(cfg_flat));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int         NUM_REGS    = 6,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_bytes,
    output logic                  use_reg_freq,
    output logic [4:0]            freq_code,
    output logic                  spread_en,
    output logic                  outputs_off
);
    localparam int CNT_W = $clog2(NUM_REGS + 3) + 1;

    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [CNT_W-1:0] wr_idx, rd_idx;
    logic [7:0]       wr_data, rd_data;

    cfg_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfg_i2c_fsm #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_i2c_regfile #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .cfg_flat (cfg_bytes)
    );

    assign use_reg_freq = cfg_bytes[3];
    assign freq_code    = {cfg_bytes[2], cfg_bytes[7:4]};
    assign spread_en    = cfg_bytes[1];
    assign outputs_off  = cfg_bytes[0];

    assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);

endmodule

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;

    localparam int Q = 10;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl   = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [47:0] cfg_bytes;
    logic        use_reg_freq;
    logic [4:0]  freq_code;
    logic        spread_en;
    logic        outputs_off;
    wire         sda_line = m_sda & ~sda_oe;

    int         checks = 0;
    int         fails  = 0;
    logic [7:0] exp_r [6];

    always #2 clk = ~clk;

    cfg_i2c_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe       (sda_oe),
        .cfg_bytes    (cfg_bytes),
        .use_reg_freq (use_reg_freq),
        .freq_code    (freq_code),
        .spread_en    (spread_en),
        .outputs_off  (outputs_off)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; qw(Q);
        scl = 1'b1;   qw(Q);
        m_sda = 1'b0; qw(Q);
        scl = 1'b0;   qw(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; qw(Q);
        scl = 1'b1;   qw(Q);
        m_sda = 1'b1; qw(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw(Q);
        scl = 1'b1; qw(2*Q);
        scl = 1'b0; qw(Q);
    endtask

    task automatic recv_bit(output logic b, output logic steady);
        logic b1;
        m_sda = 1'b1; qw(Q);
        scl = 1'b1;   qw(Q);
        b1 = sda_line; qw(Q);
        b = sda_line;
        steady = (b1 == b);
        scl = 1'b0;   qw(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b, st;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b, st);
        ack = ~b;
        if (ack) chk(st, "R10 ack level steady while SCL high", 64'(st), 64'd1);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b, st;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b, st);
            d[i] = b;
            chk(st, "R10 data bit steady while SCL high", 64'(st), 64'd1);
        end
        send_bit(~give_ack);
    endtask

    task automatic model_write(input int n, input logic [7:0] d [16]);
        for (int i = 0; i < n && i < 6; i++) exp_r[i] = d[i];
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 6; i++)
            chk(cfg_bytes[i*8 +: 8] == exp_r[i], req, 64'(cfg_bytes[i*8 +: 8]), 64'(exp_r[i]));
    endtask

    task automatic check_decode();
        chk(use_reg_freq == exp_r[0][3], "R8 frequency source select", 64'(use_reg_freq), 64'(exp_r[0][3]));
        chk(freq_code == {exp_r[0][2], exp_r[0][7:4]}, "R8 frequency code", 64'(freq_code),
            64'({exp_r[0][2], exp_r[0][7:4]}));
        chk(spread_en == exp_r[0][1], "R8 spread enable", 64'(spread_en), 64'(exp_r[0][1]));
        chk(outputs_off == exp_r[0][0], "R8 output off", 64'(outputs_off), 64'(exp_r[0][0]));
    endtask

    // full block write: address, dummy command, dummy count, n data bytes
    task automatic do_write(input int n, input logic [7:0] d [16], input string req);
        logic ack;
        logic all_ack = 1'b1;
        i2c_start();
        send_byte(8'hD2, ack);
        chk(ack, "R1 write address acknowledged", 64'(ack), 64'd1);
        send_byte(8'($urandom), ack); all_ack &= ack;
        send_byte(8'($urandom), ack); all_ack &= ack;
        chk(all_ack, "R2 dummy bytes acknowledged", 64'(all_ack), 64'd1);
        all_ack = 1'b1;
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);
            all_ack &= ack;
        end
        chk(all_ack, req, 64'(all_ack), 64'd1);
        i2c_stop();
        model_write(n, d);
    endtask

    task automatic do_read();
        logic ack;
        logic [7:0] v;
        i2c_start();
        send_byte(8'hD3, ack);
        chk(ack, "R1 read address acknowledged", 64'(ack), 64'd1);
        recv_byte(v, 1'b1);
        chk(v == 8'd6, "R6 byte count", 64'(v), 64'd6);
        for (int i = 0; i < 6; i++) begin
            recv_byte(v, i != 5);
            chk(v == exp_r[i], "R6 read data", 64'(v), 64'(exp_r[i]));
        end
        i2c_stop();
    endtask

    function automatic logic [7:0] rnd8();
        return 8'($urandom);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d [16];
        logic ack;
        logic saw_low;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6; i++) exp_r[i] = (i == 0) ? 8'h00 : 8'hFF;
        qw(5);
        rst_n = 1'b1;
        qw(5);

        // R7: power-on values
        check_regs("R7 reset value");
        chk(sda_oe == 1'b0, "R7 line released after reset", 64'(sda_oe), 64'd0);
        check_decode();
        do_read();

        // R3: full bank write
        for (int i = 0; i < 16; i++) d[i] = rnd8();
        do_write(6, d, "R3 data bytes acknowledged");
        check_regs("R3 ordered fill");
        check_decode();
        do_read();

        // R2: dummy bytes only
        do_write(0, d, "R2 no data");
        check_regs("R2 dummy bytes discarded");

        // R4: truncated write
        for (int i = 0; i < 16; i++) d[i] = rnd8();
        do_write(2, d, "R4 truncated data acknowledged");
        check_regs("R4 truncated write keeps rest");

        // R5: overrun past the last register
        for (int i = 0; i < 16; i++) d[i] = rnd8();
        do_write(9, d, "R5 overrun bytes acknowledged");
        check_regs("R5 overrun ignored");

        // R1: foreign address, no pull on the line during address ack
        i2c_start();
        send_byte(8'hA4, ack);
        chk(!ack, "R1 foreign address not acknowledged", 64'(ack), 64'd0);
        saw_low = 1'b0;
        for (int i = 0; i < 10; i++) begin
            send_bit(1'b0);
            saw_low |= sda_oe;
        end
        chk(!saw_low, "R1 line untouched after foreign address", 64'(saw_low), 64'd0);
        i2c_stop();
        check_regs("R1 registers unchanged by foreign address");

        // R9: repeated start returns to address phase and register 0
        d[0] = rnd8();
        d[1] = rnd8();
        i2c_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h01, ack);
        send_byte(d[0], ack);
        i2c_start();
        send_byte(8'hD2, ack);
        chk(ack, "R9 address after repeated start acknowledged", 64'(ack), 64'd1);
        send_byte(8'h00, ack);
        send_byte(8'h01, ack);
        send_byte(d[1], ack);
        i2c_stop();
        exp_r[0] = d[1];
        check_regs("R9 repeated start restarts at register 0");

        // random rounds
        for (int r = 0; r < 6; r++) begin
            int n;
            n = int'($urandom_range(0, 8));
            for (int i = 0; i < 16; i++) d[i] = rnd8();
            do_write(n, d, "R3 random write acknowledged");
            check_regs("R4 random write result");
            check_decode();
        end
        do_read();
        check_regs("R6 read leaves registers unchanged");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule